// File: doc/BRIEF.md
# Bus Request Grant-Chain Arbiter

This block is the bus-request front end of one peripheral slot on a daisy-chained priority bus. It keeps five request slots side by side: four interrupt levels (4 to 7) and one direct-memory-access level. Local logic raises a request by naming a slot and supplying an interrupt vector, plus a register handle and value. The block then drives the matching request line and, for interrupt slots, emits the register write in the same cycle the line goes up.

The block watches the incoming grant lines. A grant on a level where the slot has no claim is passed down the chain to the outgoing grant line. A rising grant on a level with a pending request is kept by the slot. In that case the request line drops, the selection acknowledge rises and the interrupt or DMA engine is started with the slot's vector. The acknowledge stays up until the engine reports done. The block then emits a completion pulse with the slot index, and the level may be requested again. A pending interrupt request can be withdrawn before it is granted. A bus initialize pulse returns everything to idle.

Top module: `bus_grant_arbiter`

## Requirements
- R1: After reset, and in the cycle after `bus_init` is high, all request lines, outgoing grants, the acknowledge and all pulse outputs are 0, every slot is idle, and the held output fields read 0.
- R2: Slot index `req_slot` values 0, 1, 2 and 3 select interrupt levels 4, 5, 6 and 7, and value 4 selects DMA. `request_out` bit n belongs to slot n, so the masks are 0x01, 0x02, 0x04 and 0x08 for levels 4 to 7 and 0x10 for DMA. A raise on an idle slot sets that bit at the next clock edge. A raise with slot codes 5 to 7 is ignored.
- R3: A raise on a slot that is pending or in transfer is ignored: the request lines are unchanged and the stored vector is kept.
- R4: `grant_out` bit n equals `grant_in` bit n one cycle later, whenever slot n had neither a pending request nor a held claim.
- R5: A rising `grant_in` bit on a pending slot, while no transfer is active, is captured. The request bit clears at the next edge. The outgoing grant of that level stays 0 from then until `grant_in` has gone low. A pending slot never forwards its grant.
- R6: `sel_ack` rises at the edge that captures a grant and stays high until the edge that sees `xfer_done`.
- R7: On capture, `start_intr` (slots 0 to 3) or `start_dma` (slot 4) pulses for one cycle. At the same time `start_vector` and `start_slot` take the slot's stored vector and index, and they hold those values until the next capture.
- R8: When an interrupt slot (0 to 3) is raised, `reg_wr_en` pulses in the same cycle that its request bit first reads 1, with `reg_wr_handle` and `reg_wr_value` from the raise. A DMA raise gives no register write.
- R9: `cancel_valid` with `cancel_slot` 0 to 3 clears a pending, not-yet-captured interrupt request at the next edge. A cancel naming slot 4 or higher, or naming a slot that is not pending, has no effect.
- R10: `xfer_done` while a transfer is active drops `sel_ack`, pulses `done_pulse` for one cycle with `done_slot` set to the slot, and frees that slot for a new raise from the next cycle on. `xfer_done` with no transfer active is ignored.
- R11: Only one transfer is active at a time. When several pending slots see rising grants in the same cycle, the highest index wins (DMA, then level 7 down to level 4), and the others stay pending. A rising grant that arrives while a transfer is active is not captured, and its request stays up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Synchronous bus initialize, clears all state |
| req_valid | input | 1 | Raise a request on `req_slot` |
| req_slot | input | 3 | Slot index of the raise (0-3 interrupt levels 4-7, 4 DMA) |
| req_vector | input | 16 | Vector stored with the request |
| req_handle | input | 8 | Register handle written with an interrupt raise |
| req_value | input | 16 | Register value written with an interrupt raise |
| cancel_valid | input | 1 | Withdraw a pending interrupt request |
| cancel_slot | input | 3 | Slot index of the withdrawal |
| grant_in | input | 5 | Incoming grant lines, bit n for slot n |
| xfer_done | input | 1 | Transfer engine completion |
| request_out | output | 5 | Request lines, bit n for slot n |
| grant_out | output | 5 | Outgoing grant lines passed down the chain |
| sel_ack | output | 1 | Selection acknowledge held during a transfer |
| start_intr | output | 1 | One-cycle start of the interrupt engine |
| start_dma | output | 1 | One-cycle start of the DMA engine |
| start_vector | output | 16 | Vector of the captured slot |
| start_slot | output | 3 | Index of the captured slot |
| reg_wr_en | output | 1 | Register write pulse that goes with a raised interrupt line |
| reg_wr_handle | output | 8 | Handle of that register write |
| reg_wr_value | output | 16 | Value of that register write |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_slot | output | 3 | Slot that completed |

## Verification
The assertions check the following on every cycle:
- a start pulse always comes with the acknowledge high, a cleared request bit and a blocked outgoing grant for that level;
- start and completion pulses never coincide;
- a completion pulse always comes with the acknowledge low;
- a register write pulse always has an interrupt request line up;
- a bus initialize leaves everything clear one cycle later.

Some behaviours only the bench's scenarios can show:
- a refused raise keeps the first vector;
- a cancel on the DMA slot has no effect;
- the highest index wins among simultaneous grants;
- a grant that arrives during a transfer is left pending;
- a freed level can be raised again.

The bench establishes these against a cycle model over directed and random grant, raise, cancel and completion patterns.

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int NUM_INTR = 4,
  parameter int VEC_W    = 16,
  parameter int HND_W    = 8,
  parameter int VAL_W    = 16,
  localparam int NSLOT   = NUM_INTR + 1,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic [HND_W-1:0]  req_handle,
  input  logic [VAL_W-1:0]  req_value,
  input  logic              cancel_valid,
  input  logic [SLOT_W-1:0] cancel_slot,
  input  logic [NSLOT-1:0]  grant_in,
  input  logic              xfer_done,
  output logic [NSLOT-1:0]  request_out,
  output logic [NSLOT-1:0]  grant_out,
  output logic              sel_ack,
  output logic              start_intr,
  output logic              start_dma,
  output logic [VEC_W-1:0]  start_vector,
  output logic [SLOT_W-1:0] start_slot,
  output logic              reg_wr_en,
  output logic [HND_W-1:0]  reg_wr_handle,
  output logic [VAL_W-1:0]  reg_wr_value,
  output logic              done_pulse,
  output logic [SLOT_W-1:0] done_slot
);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_BUSY} slot_st_e;

  slot_st_e          st  [NSLOT];
  logic [VEC_W-1:0]  vec [NSLOT];
  logic [NSLOT-1:0]  claim, gprev, pend, rise;
  logic              active, take_hit;
  logic [SLOT_W-1:0] aslot, take_idx;
  logic              raise_ok, cancel_ok;

  assign rise = grant_in & ~gprev;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign pend[g] = (st[g] == S_PEND);
  end

  assign request_out = pend;

  always_comb begin
    take_hit = 1'b0;
    take_idx = '0;
    if (!active)
      for (int i = 0; i < NSLOT; i++)
        if (pend[i] && rise[i]) begin
          take_hit = 1'b1;
          take_idx = SLOT_W'(i);
        end
  end

  assign raise_ok  = req_valid && (int'(req_slot) < NSLOT) && (st[req_slot] == S_IDLE);
  assign cancel_ok = cancel_valid && (int'(cancel_slot) < NUM_INTR) && pend[cancel_slot] &&
                     !(take_hit && take_idx == cancel_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        st[i]  <= S_IDLE;
        vec[i] <= '0;
      end
      claim <= '0; gprev <= '0; grant_out <= '0;
      active <= 1'b0; aslot <= '0; sel_ack <= 1'b0;
      start_intr <= 1'b0; start_dma <= 1'b0; start_vector <= '0; start_slot <= '0;
      reg_wr_en <= 1'b0; reg_wr_handle <= '0; reg_wr_value <= '0;
      done_pulse <= 1'b0; done_slot <= '0;
    end else if (bus_init) begin
      for (int i = 0; i < NSLOT; i++) begin
        st[i]  <= S_IDLE;
        vec[i] <= '0;
      end
      claim <= '0; gprev <= grant_in; grant_out <= '0;
      active <= 1'b0; aslot <= '0; sel_ack <= 1'b0;
      start_intr <= 1'b0; start_dma <= 1'b0; start_vector <= '0; start_slot <= '0;
      reg_wr_en <= 1'b0; reg_wr_handle <= '0; reg_wr_value <= '0;
      done_pulse <= 1'b0; done_slot <= '0;
    end else begin
      gprev      <= grant_in;
      grant_out  <= grant_in & ~(pend | claim);
      claim      <= (claim & grant_in) | (take_hit ? (NSLOT'(1) << take_idx) : '0);
      start_intr <= take_hit && (int'(take_idx) < NUM_INTR);
      start_dma  <= take_hit && (int'(take_idx) == NUM_INTR);
      done_pulse <= 1'b0;
      reg_wr_en  <= 1'b0;

      if (take_hit) begin
        st[take_idx] <= S_BUSY;
        start_vector <= vec[take_idx];
        start_slot   <= take_idx;
        active       <= 1'b1;
        aslot        <= take_idx;
        sel_ack      <= 1'b1;
      end

      if (xfer_done && active) begin
        st[aslot]  <= S_IDLE;
        active     <= 1'b0;
        sel_ack    <= 1'b0;
        done_pulse <= 1'b1;
        done_slot  <= aslot;
      end

      if (cancel_ok)
        st[cancel_slot] <= S_IDLE;

      if (raise_ok) begin
        st[req_slot]  <= S_PEND;
        vec[req_slot] <= req_vector;
        if (int'(req_slot) < NUM_INTR) begin
          reg_wr_en     <= 1'b1;
          reg_wr_handle <= req_handle;
          reg_wr_value  <= req_value;
        end
      end
    end
  end

  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (request_out == '0 && grant_out == '0 && !sel_ack));

  // R5
  start_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_intr || start_dma) |-> !request_out[start_slot]);

  // R5
  start_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_intr || start_dma) |-> !grant_out[start_slot]);

  // R6
  start_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_intr || start_dma) |-> sel_ack);

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_intr, start_dma, done_pulse}));

  // R8
  regwr_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (request_out[NUM_INTR-1:0] != '0));

  // R10
  done_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !sel_ack);

endmodule

// File: tb/test_bus_grant_arbiter.sv
module test_bus_grant_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_slot = '0;
  logic [15:0] req_vector = '0;
  logic [7:0]  req_handle = '0;
  logic [15:0] req_value = '0;
  logic        cancel_valid = 1'b0;
  logic [2:0]  cancel_slot = '0;
  logic [4:0]  grant_in = '0;
  logic        xfer_done = 1'b0;
  logic [4:0]  request_out, grant_out;
  logic        sel_ack, start_intr, start_dma, reg_wr_en, done_pulse;
  logic [15:0] start_vector, reg_wr_value;
  logic [2:0]  start_slot, done_slot;
  logic [7:0]  reg_wr_handle;

  always #2 clk = ~clk;

  bus_grant_arbiter i_bus_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
    .req_valid(req_valid), .req_slot(req_slot), .req_vector(req_vector),
    .req_handle(req_handle), .req_value(req_value),
    .cancel_valid(cancel_valid), .cancel_slot(cancel_slot),
    .grant_in(grant_in), .xfer_done(xfer_done),
    .request_out(request_out), .grant_out(grant_out), .sel_ack(sel_ack),
    .start_intr(start_intr), .start_dma(start_dma), .start_vector(start_vector),
    .start_slot(start_slot), .reg_wr_en(reg_wr_en), .reg_wr_handle(reg_wr_handle),
    .reg_wr_value(reg_wr_value), .done_pulse(done_pulse), .done_slot(done_slot)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  int          mst [5];
  logic [15:0] mvec [5];
  logic [4:0]  mclaim, mgprev;
  bit          mact;
  int          maslot;
  logic [4:0]  e_req, e_gout;
  logic        e_ack, e_si, e_sd, e_rw, e_dp;
  logic [15:0] e_sv, e_rv;
  logic [2:0]  e_ss, e_ds;
  logic [7:0]  e_rh;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 5; i++) begin mst[i] = 0; mvec[i] = '0; end
    mclaim = '0; mact = 1'b0; maslot = 0;
    e_gout = '0; e_ack = 0; e_si = 0; e_sd = 0; e_sv = '0; e_ss = '0;
    e_rw = 0; e_rh = '0; e_rv = '0; e_dp = 0; e_ds = '0;
  endtask

  function automatic logic [4:0] pend_mask();
    logic [4:0] m = '0;
    for (int i = 0; i < 5; i++) m[i] = (mst[i] == 1);
    return m;
  endfunction

  task automatic model_step();
    logic [4:0] rise, pold;
    int take;
    int ost [5];
    if (bus_init) begin
      model_clear();
      mgprev = grant_in;
    end else begin
      for (int i = 0; i < 5; i++) ost[i] = mst[i];
      pold = pend_mask();
      rise = grant_in & ~mgprev;
      take = -1;
      if (!mact)
        for (int i = 4; i >= 0; i--)
          if (take < 0 && pold[i] && rise[i]) take = i;
      e_gout = grant_in & ~(pold | mclaim);
      mclaim = mclaim & grant_in;
      e_si = (take >= 0 && take < 4);
      e_sd = (take == 4);
      e_dp = 0;
      e_rw = 0;
      if (take >= 0) begin
        mclaim[take] = 1'b1;
        mst[take] = 2; e_sv = mvec[take]; e_ss = 3'(take);
        mact = 1; maslot = take; e_ack = 1;
      end else if (xfer_done && mact) begin
        mst[maslot] = 0; mact = 0; e_ack = 0; e_dp = 1; e_ds = 3'(maslot);
      end
      if (cancel_valid && cancel_slot < 4 && ost[cancel_slot] == 1 && take != int'(cancel_slot))
        mst[cancel_slot] = 0;
      if (req_valid && req_slot < 5 && ost[req_slot] == 0) begin
        mst[req_slot] = 1; mvec[req_slot] = req_vector;
        if (req_slot < 4) begin e_rw = 1; e_rh = req_handle; e_rv = req_value; end
      end
      mgprev = grant_in;
    end
    e_req = pend_mask();
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    check("R2 request_out", 32'(request_out), 32'(e_req));
    check("R4/R5 grant_out", 32'(grant_out), 32'(e_gout));
    check("R6 sel_ack", 32'(sel_ack), 32'(e_ack));
    check("R7 start_intr/dma", 32'({start_intr, start_dma}), 32'({e_si, e_sd}));
    check("R7 start_vector/slot", 32'({start_vector, start_slot}), 32'({e_sv, e_ss}));
    check("R8 reg_wr", 32'({reg_wr_en, reg_wr_handle, reg_wr_value}), 32'({e_rw, e_rh, e_rv}));
    check("R10 done", 32'({done_pulse, done_slot}), 32'({e_dp, e_ds}));
    req_valid = 0; cancel_valid = 0; xfer_done = 0; bus_init = 0;
  endtask

  task automatic raise(int s, logic [15:0] v, logic [7:0] h, logic [15:0] val);
    req_valid = 1; req_slot = 3'(s); req_vector = v; req_handle = h; req_value = val;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed = 7;
    void'($urandom(seed));
    model_clear();
    mgprev = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset request_out", 32'(request_out), 0);
    check("R1 reset sel_ack/grant_out", 32'({sel_ack, grant_out}), 0);
    rst_n = 1;

    raise(2, 16'h0120, 8'h05, 16'hBEEF); cycle();
    check("R2 level6 mask 0x04", 32'(request_out), 32'h04);
    check("R8 reg write handle", 32'(reg_wr_handle), 32'h05);
    raise(2, 16'h0777, 8'h06, 16'h1111); cycle();
    check("R3 second raise ignored", 32'({request_out, reg_wr_en}), 32'({5'h04, 1'b0}));
    raise(6, 16'h0001, 8'h00, 16'h0); cycle();
    check("R2 code 6 ignored", 32'(request_out), 32'h04);
    grant_in = 5'b00001; cycle(); cycle();
    check("R4 pass level4", 32'(grant_out[0]), 1);
    grant_in = 5'b00101; cycle();
    check("R5 request cleared", 32'(request_out), 0);
    check("R7 start vector kept first", 32'(start_vector), 32'h0120);
    check("R6 ack up", 32'(sel_ack), 1);
    cycle();
    check("R5 grant held back", 32'(grant_out[2]), 0);
    grant_in = 5'b00000; cycle();
    raise(4, 16'h0BAD, 8'h00, 16'h0); cycle();
    check("R8 no reg write for DMA", 32'(reg_wr_en), 0);
    grant_in = 5'b10000; cycle();
    check("R11 no capture while busy", 32'({request_out[4], start_dma}), 32'({1'b1, 1'b0}));
    check("R5 pending slot blocks grant", 32'(grant_out[4]), 0);
    xfer_done = 1; cycle();
    check("R10 done slot 2", 32'({done_pulse, done_slot, sel_ack}), 32'({1'b1, 3'd2, 1'b0}));
    grant_in = 5'b00000; cycle();
    xfer_done = 1; cycle();
    check("R10 idle done ignored", 32'(done_pulse), 0);
    raise(2, 16'h0222, 8'h07, 16'h2222); cycle();
    check("R10 level reusable", 32'(request_out), 32'h14);
    cancel_valid = 1; cancel_slot = 3'd4; cycle();
    check("R9 DMA cancel ignored", 32'(request_out), 32'h14);
    cancel_valid = 1; cancel_slot = 3'd2; cycle();
    check("R9 cancel level6", 32'(request_out), 32'h10);
    raise(3, 16'h0333, 8'h08, 16'h3333); cycle();
    grant_in = 5'b11000; cycle();
    check("R11 DMA wins", 32'({start_dma, start_slot, request_out}), 32'({1'b1, 3'd4, 5'h08}));
    xfer_done = 1; grant_in = 5'b00000; cycle();
    bus_init = 1; cycle();
    check("R1 init clears", 32'({request_out, grant_out, sel_ack}), 0);

    for (int k = 0; k < 6000; k++) begin
      if ($urandom % 4 == 0)
        raise(int'($urandom % 8), 16'($urandom), 8'($urandom), 16'($urandom));
      if ($urandom % 8 == 0) begin cancel_valid = 1; cancel_slot = 3'($urandom); end
      for (int b = 0; b < 5; b++) if ($urandom % 6 == 0) grant_in[b] = ~grant_in[b];
      if ($urandom % 5 == 0) xfer_done = 1;
      if ($urandom % 300 == 0) bus_init = 1;
      cycle();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule